// File: doc/BRIEF.md
# UART Modem Handshake Control and Status

This block owns the modem handshake pins of a 16550-style serial port. A small register port lets software write a control byte that drives the two active-low request outputs, data-terminal-ready and request-to-send. The same port reads a status byte that reports the three active-low inputs (data-set-ready, carrier-detect and ring-indicator) as active-high levels. Alongside those levels it keeps sticky change flags that record activity since the previous status read.

The inputs are asynchronous. They pass through a multi-stage synchronizer before any edge is detected. Data-set-ready and carrier-detect flag every change. Ring-indicator flags only the return of the ring signal to its idle level. Reading the status register clears all change flags. An edge that lands on the same clock edge as the clearing read is kept. While any flag is set and the external modem-interrupt enable is high, the block raises an interrupt request. A loop-mode bit in the control register forces both handshake outputs to their idle level.

Top module: `uart_modem_ctl`

## Requirements
- R1: With loop mode off, control bit 0 = 1 drives `dtr_n_o` low and control bit 1 = 1 drives `rts_n_o` low. A 0 in either bit drives the matching pin high.
- R2: After reset, `dtr_n_o` and `rts_n_o` are 1, `irq_o` is 0, the control register reads 0x00, and with all inputs idle (high) the status register reads 0x00.
- R3: While control bit 4 (loop mode) is 1, `dtr_n_o` and `rts_n_o` are both 1 whatever bits 0 and 1 hold. Clearing bit 4 restores the outputs those bits select.
- R4: Control bits 2, 3, 5, 6 and 7 are reserved. Writes to them are ignored and they read as 0, so writing 0xFF reads back 0x13.
- R5: Status bit 5 is the inverse of the synchronized `dsr_n_i`, bit 6 the inverse of `ri_n_i`, and bit 7 the inverse of `dcd_n_i`.
- R6: Status bit 1 sets on any change of `dsr_n_i`, and status bit 3 sets on any change of `dcd_n_i`. Both stay set until a status read.
- R7: Status bit 2 sets only when `ri_n_i` goes from low to high, which is when status bit 6 goes from 1 to 0. A high-to-low change of `ri_n_i` leaves bit 2 clear.
- R8: A status read returns the value held before the read and then clears bits 1, 2 and 3. A change flagged on the same clock edge as the read stays set.
- R9: `irq_o` is 1 exactly when `msi_en_i` is 1 and any of status bits 1, 2, 3 is set. It falls after the status read that clears them.
- R10: Status bits 0 and 4 read 0. Writes to the status offset change nothing. Reads of unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register offset (control at 4, status at 6 by default) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a status read clears the change flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, same cycle |
| msi_en_i | input | 1 | Modem status interrupt enable |
| dsr_n_i | input | 1 | Data-set-ready, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier-detect, active low, asynchronous |
| ri_n_i | input | 1 | Ring-indicator, active low, asynchronous |
| dtr_n_o | output | 1 | Data-terminal-ready, active low |
| rts_n_o | output | 1 | Request-to-send, active low |
| irq_o | output | 1 | Modem status interrupt request |

## Verification
The bench aims a status read at the exact cycle in which a synchronized carrier-detect edge is being flagged. A design that lets the clear win would lose that change, and the follow-up read would show 0x00 in place of 0x08. Ring-indicator is driven both ways. A design that flags the leading edge would return 0xE4 in place of 0xE0, and one that misses the trailing edge would leave the interrupt low. Writing 0xFF to the control register exposes reserved bits that were stored, and also outputs that ignore loop mode. A write to the status offset would show up as corrupted flags.

// File: rtl/modem_pkg.sv
package modem_pkg;
   localparam int DATA_W = 8;

   // control byte fields
   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_LOOP = 4;
   localparam logic [DATA_W-1:0] CB_MASK =
      DATA_W'((1 << CB_DTR) | (1 << CB_RTS) | (1 << CB_LOOP));

   // monitored line index
   typedef enum int {LN_DSR = 0, LN_RI = 1, LN_DCD = 2} line_e;
   localparam int NUM_LINES = 3;
   localparam logic [NUM_LINES-1:0] TRAIL_MASK = NUM_LINES'(1 << LN_RI);
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("modem_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("modem_sync: WIDTH must be positive");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/modem_delta.sv
module modem_delta #(
   parameter int               WIDTH      = 3,
   parameter logic [WIDTH-1:0] TRAIL_ONLY = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] line_n_i,
   input  logic             clr_i,
   output logic [WIDTH-1:0] level_o,
   output logic [WIDTH-1:0] ev_o,
   output logic [WIDTH-1:0] flag_o
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] flag_q;
   logic [WIDTH-1:0] ev;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_line
         if (TRAIL_ONLY[i]) begin : g_trail
            // only the return to the idle (high) level counts
            assign ev[i] = !prev_q[i] && line_n_i[i];

            assert_no_lead_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
               (!flag_q[i] && prev_q[i] && !line_n_i[i] && !clr_i) |=> !flag_q[i]);
         end else begin : g_any
            assign ev[i] = prev_q[i] ^ line_n_i[i];
         end

         assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_i) |=> flag_q[i]);
         assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !ev[i]) |=> !flag_q[i]);
         assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> flag_q[i]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '1;
         flag_q <= '0;
      end else begin
         prev_q <= line_n_i;
         flag_q <= (flag_q & ~{WIDTH{clr_i}}) | ev;
      end
   end

   assign level_o = ~line_n_i;
   assign ev_o    = ev;
   assign flag_o  = flag_q;
endmodule

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg #(
   parameter int                DATA_W = 8,
   parameter logic [DATA_W-1:0] MASK   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] q_o
);
   logic [DATA_W-1:0] ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_i) begin
         ctl_q <= wdata_i & MASK;
      end
   end

   assign q_o = ctl_q;

   assert_hold_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(ctl_q));
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl #(
   parameter int ADDR_W      = 3,
   parameter int CTRL_OFFSET = 4,
   parameter int STAT_OFFSET = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              msi_en_i,
   input  logic              dsr_n_i,
   input  logic              dcd_n_i,
   input  logic              ri_n_i,
   output logic              dtr_n_o,
   output logic              rts_n_o,
   output logic              irq_o
);
   import modem_pkg::*;

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFFSET);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFFSET);

   generate
      if (CTRL_OFFSET == STAT_OFFSET) begin : g_bad_map
         $error("uart_modem_ctl: register offsets collide");
      end
      if (CTRL_OFFSET >= (1 << ADDR_W) || STAT_OFFSET >= (1 << ADDR_W)) begin : g_bad_addr
         $error("uart_modem_ctl: offset outside address range");
      end
   endgenerate

   logic                 ctrl_sel, stat_sel;
   logic [DATA_W-1:0]    ctrl_q, stat_byte;
   logic [NUM_LINES-1:0] raw_n, sync_n, lvl, ev, flag;
   logic                 stat_clr;

   assign ctrl_sel = (reg_addr == CTRL_A);
   assign stat_sel = (reg_addr == STAT_A);
   assign stat_clr = reg_rd && stat_sel;

   modem_ctrl_reg #(.DATA_W(DATA_W), .MASK(CB_MASK)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr && ctrl_sel),
      .wdata_i(reg_wdata), .q_o(ctrl_q));

   always_comb begin
      raw_n         = '1;
      raw_n[LN_DSR] = dsr_n_i;
      raw_n[LN_RI]  = ri_n_i;
      raw_n[LN_DCD] = dcd_n_i;
   end

   modem_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_n), .q_o(sync_n));

   modem_delta #(.WIDTH(NUM_LINES), .TRAIL_ONLY(TRAIL_MASK)) u_delta (
      .clk(clk), .rst_n(rst_n), .line_n_i(sync_n), .clr_i(stat_clr),
      .level_o(lvl), .ev_o(ev), .flag_o(flag));

   always_comb begin
      stat_byte    = '0;
      stat_byte[1] = flag[LN_DSR];
      stat_byte[2] = flag[LN_RI];
      stat_byte[3] = flag[LN_DCD];
      stat_byte[5] = lvl[LN_DSR];
      stat_byte[6] = lvl[LN_RI];
      stat_byte[7] = lvl[LN_DCD];
   end

   always_comb begin
      if (ctrl_sel)      reg_rdata = ctrl_q;
      else if (stat_sel) reg_rdata = stat_byte;
      else               reg_rdata = '0;
   end

   assign dtr_n_o = ~(ctrl_q[CB_DTR] & ~ctrl_q[CB_LOOP]);
   assign rts_n_o = ~(ctrl_q[CB_RTS] & ~ctrl_q[CB_LOOP]);
   assign irq_o   = msi_en_i & (|flag);

   assert_loop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[CB_LOOP] |-> (dtr_n_o && rts_n_o));
   assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !msi_en_i |-> !irq_o);
   assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && ev == '0) |=> !irq_o);
   assert_rsvd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && ctrl_sel) |=> (ctrl_q & ~CB_MASK) == '0);
endmodule

// File: tb/uart_modem_ctl_tb.sv
module uart_modem_ctl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       msi_en_i = 1'b0;
   logic       dsr_n_i = 1'b1, dcd_n_i = 1'b1, ri_n_i = 1'b1;
   logic       dtr_n_o, rts_n_o, irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   localparam logic [2:0] A_CTRL = 3'd4;
   localparam logic [2:0] A_STAT = 3'd6;

   always #4 clk = ~clk;

   uart_modem_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .msi_en_i(msi_en_i), .dsr_n_i(dsr_n_i), .dcd_n_i(dcd_n_i),
      .ri_n_i(ri_n_i), .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o), .irq_o(irq_o));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares read data mid-cycle, before the clearing edge
   always @(negedge clk) begin
      #2;
      if (reg_rd && exp_q.size() > 0) begin
         chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
   end

   task automatic do_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      reg_addr = a;
      reg_rd   = 1'b1;
      @(negedge clk);
      reg_rd   = 1'b0;
   endtask

   task automatic do_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic pins(input logic [1:0] exp, input string tag);
      @(negedge clk);
      chk(tag, {6'd0, rts_n_o, dtr_n_o}, {6'd0, exp});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state
      pins(2'b11, "R2 pins idle after reset");
      chk("R2 irq low after reset", {7'd0, irq_o}, 8'd0);
      do_read(A_CTRL, 8'h00, "R2 control reads zero");
      do_read(A_STAT, 8'h00, "R2 status reads zero");

      // R1 drive from control bits (pins = {rts_n, dtr_n})
      do_write(A_CTRL, 8'h01); pins(2'b10, "R1 dtr only");
      do_write(A_CTRL, 8'h02); pins(2'b01, "R1 rts only");
      do_write(A_CTRL, 8'h03); pins(2'b00, "R1 both");

      // R3 loop mode
      do_write(A_CTRL, 8'h13); pins(2'b11, "R3 loop forces idle");
      do_write(A_CTRL, 8'h03); pins(2'b00, "R3 loop cleared restores");

      // R4 reserved bits
      do_write(A_CTRL, 8'hFF);
      do_read(A_CTRL, 8'h13, "R4 reserved bits read zero");
      pins(2'b11, "R4 R3 all-ones write keeps idle in loop");
      do_write(A_CTRL, 8'hEC);
      do_read(A_CTRL, 8'h00, "R4 reserved-only write ignored");

      // R5 R6 R9 dsr change, enable off first
      dsr_n_i = 1'b0; settle();
      chk("R9 irq masked while disabled", {7'd0, irq_o}, 8'd0);
      msi_en_i = 1'b1; #1;
      chk("R9 irq follows enable", {7'd0, irq_o}, 8'd1);
      do_read(A_STAT, 8'h22, "R5 R6 dsr level and change");
      @(negedge clk);
      chk("R9 irq drops after read", {7'd0, irq_o}, 8'd0);
      do_read(A_STAT, 8'h20, "R8 change flag cleared");

      // R6 dcd change
      dcd_n_i = 1'b0; settle();
      chk("R9 irq on dcd change", {7'd0, irq_o}, 8'd1);
      do_read(A_STAT, 8'hA8, "R6 dcd level and change");
      do_read(A_STAT, 8'hA0, "R8 dcd flag cleared");

      // R7 ring leading edge: no flag
      ri_n_i = 1'b0; settle();
      chk("R7 no irq on ring onset", {7'd0, irq_o}, 8'd0);
      do_read(A_STAT, 8'hE0, "R7 ring onset not flagged");
      ri_n_i = 1'b1; settle();
      chk("R7 irq on ring trailing edge", {7'd0, irq_o}, 8'd1);
      do_read(A_STAT, 8'hA4, "R7 ring trailing edge flagged");
      do_read(A_STAT, 8'hA0, "R8 ring flag cleared");

      // R6 dsr release
      dsr_n_i = 1'b1; settle();
      do_read(A_STAT, 8'h82, "R6 dsr release flagged");

      // R8 read in the same cycle as the flagging edge
      @(negedge clk);
      dcd_n_i = 1'b1;
      @(posedge clk);
      @(posedge clk);
      do_read(A_STAT, 8'h00, "R8 read during edge returns old flags");
      do_read(A_STAT, 8'h08, "R8 colliding edge kept");
      do_read(A_STAT, 8'h00, "R8 cleared after second read");

      // R10 status writes ignored, unused bits, unmapped offset
      do_write(A_STAT, 8'hFF);
      do_read(A_STAT, 8'h00, "R10 status write ignored");
      do_read(3'd0, 8'h00, "R10 unmapped offset reads zero");
      pins(2'b11, "R10 pins unchanged by status write");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) chk("scoreboard drained", 8'(exp_q.size()), 8'd0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule